// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers a parameterised set of interrupt sources, 32 by default and 256 at most. Each source has its own trigger sense and enable bit. At most one request to the processor is outstanding at any time. That request is a 16-bit word that combines the source's priority with its vector number. A fast-interrupt register can send the request to a second output instead of the normal one. When the processor acknowledges the current request, the controller rescans every pending source and requests the one with the highest priority.

Software reaches the controller through a byte-addressed register port. The address space is split into four regions by address bits 9:8: request flags (0), enable bytes (1), priority bytes (2), and control (3). The control region holds the pin trigger-mode bytes at offsets below the pin count, a software-interrupt trigger at offset 0xF0, and the 16-bit fast-interrupt register at offset 0xF2. The port input `bus_size` is 0 for a byte access and 1 for a halfword access. Source inputs pass through a synchronizer, so a change on an input reaches the request outputs three clock edges later.

Top module: `vec_intc`

## Requirements
- R1: After reset, both request outputs are zero, every flag, enable and priority reads zero, and each pin trigger-mode byte reads 0x08 (rising edge).
- R2: The trigger sense is a 2-bit code: 0 is active-low level, 1 is falling edge, 2 is rising edge and 3 is both edges. An edge sets the source's request flag. In level mode, the flag follows whether the level is active.
- R3: Sources PIN_BASE to PIN_BASE+N_PIN-1 take their trigger code from bits 3:2 of the control byte at offset (source minus PIN_BASE). The byte reads back with the code in the same bits. All other sources are rising-edge, unless their bit in FIXED_LOW is set, in which case they are low-level.
- R4: The request word is the source's 8-bit priority in bits 15:8 and its source number in bits 7:0. Source n uses the priority byte at index n >> MAP_SHIFT.
- R5: A new request is raised only for a nonzero source whose enable bit is set, and only while no request is outstanding. An outstanding request keeps its source until it is acknowledged or dropped.
- R6: Enable bits are packed eight per byte. Source n uses enable byte n/8, bit n mod 8. A disabled source sets its flag but raises no request.
- R7: The fast-interrupt register holds an enable in bit 15 and a vector in bits 7:0. When it is enabled and the vector matches the outstanding source, the request word appears on `fast_level` and `irq_level` is zero. Otherwise the word appears on `irq_level`. The two outputs are never nonzero together.
- R8: A level-mode source that is outstanding and whose level goes inactive drops the request, and both outputs return to zero.
- R9: An acknowledge while a request is outstanding clears that request, and also clears the source's flag if the source is edge-triggered. The controller then requests, in the same cycle, the enabled nonzero flagged source with the highest priority, choosing the lowest source number on a tie.
- R10: Writing a byte with bit 0 clear to a flag clears it for edge-triggered sources only. Writing a 1 does nothing, and level-mode flags are unaffected.
- R11: A byte write with bit 0 set to the software-interrupt offset produces a one-cycle pulse on `swi_pulse` in the cycle after the write.
- R12: The fast-interrupt register accepts only halfword accesses, and all other registers accept only byte accesses. A wrong-size write is ignored and a wrong-size read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Asynchronous interrupt source inputs |
| ack_in | input | 1 | Single-cycle acknowledge of the outstanding request |
| bus_wr | input | 1 | Register write strobe |
| bus_size | input | 1 | Access size: 0 byte, 1 halfword |
| bus_addr | input | 10 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address and size |
| irq_level | output | 16 | Normal request word, zero when idle |
| fast_level | output | 16 | Fast request word, zero when idle |
| swi_pulse | output | 1 | Software-interrupt pulse |

## Verification
The assertions assume that `ack_in` is a single-cycle strobe and that the software-interrupt trigger is never written on two consecutive cycles. The bench only ever drives isolated write and acknowledge strobes, each lasting one clock. Source inputs are changed only while the block is settled. They are held steady for at least three edges, so that each edge reaches the flags exactly once and the expected request can be sampled at a known cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    localparam int BUS_AW = 10;

    // region select is address bits 9:8
    localparam logic [1:0] RGN_FLAG = 2'd0;
    localparam logic [1:0] RGN_EN   = 2'd1;
    localparam logic [1:0] RGN_PRIO = 2'd2;
    localparam logic [1:0] RGN_CTRL = 2'd3;

    localparam logic [7:0] OFF_SWI  = 8'hF0;
    localparam logic [7:0] OFF_FAST = 8'hF2;

    typedef struct packed {
        logic       en;
        logic [7:0] vec;
    } fast_t;

    typedef struct packed {
        logic [7:0] prio;
        logic [7:0] vec;
    } level_t;

    // event detection for one source: cur is synchronized, prv one cycle older
    function automatic logic trig_hit(trig_e m, logic cur, logic prv);
        case (m)
            TRIG_LOW:  return !cur;
            TRIG_FALL: return prv && !cur;
            TRIG_RISE: return !prv && cur;
            default:   return prv ^ cur;
        endcase
    endfunction

endpackage

// File: rtl/vic_src_front.sv
module vic_src_front
    import vic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  raw,
    input  trig_e mode,
    output logic  hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= (sync_q << 1) | SYNC_STAGES'(raw);
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign hit = trig_hit(mode, sync_q[SYNC_STAGES-1], prev_q);
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
    parameter int N  = 32,
    parameter int PW = 8,
    parameter int IW = 5
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 found,
    output logic [IW-1:0]        idx
);
    logic [PW-1:0] best;

    // ascending scan, strictly-greater replace: lowest index wins ties
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio[i] > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vic_pkg::*;
#(
    parameter int               N_SRC       = 32,
    parameter int               N_PIN       = 8,
    parameter int               PIN_BASE    = 16,
    parameter int               MAP_SHIFT   = 1,
    parameter int               SYNC_STAGES = 2,
    parameter logic [N_SRC-1:0] FIXED_LOW   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              ack_in,
    input  logic              bus_wr,
    input  logic              bus_size,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [15:0]       irq_level,
    output logic [15:0]       fast_level,
    output logic              swi_pulse
);
    localparam int IW     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int N_EN   = N_SRC / 8;
    localparam int N_PRIO = (N_SRC + (1 << MAP_SHIFT) - 1) >> MAP_SHIFT;
    localparam int EN_IW  = (N_EN > 1) ? $clog2(N_EN) : 1;
    localparam int PR_IW  = (N_PRIO > 1) ? $clog2(N_PRIO) : 1;
    localparam int PIN_IW = (N_PIN > 1) ? $clog2(N_PIN) : 1;

    logic [N_SRC-1:0]         hit, flag_q, flag_d, en_bits, ack_edge, pick_cand;
    logic [N_EN-1:0][7:0]     en_q;
    logic [N_PRIO-1:0][7:0]   prio_q;
    logic [N_SRC-1:0][7:0]    src_prio;
    trig_e                    pin_mode_q [N_PIN];
    trig_e                    src_mode   [N_SRC];
    fast_t                    fast_q;
    logic                     req_valid, swi_q, pick_found, ack_take, steer;
    logic [IW-1:0]            req_src, pick_idx;
    level_t                   word;

    logic [1:0] rgn;
    logic [7:0] off;
    logic wr_byte, wr_half, wr_flag, wr_en, wr_prio, wr_pin, wr_swi, wr_fast;
    logic unused_wbits;

    assign rgn          = bus_addr[9:8];
    assign off          = bus_addr[7:0];
    assign unused_wbits = ^bus_wdata[14:8];
    assign en_bits      = en_q;

    // ---------------- per-source front end ----------------
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign src_prio[g] = prio_q[g >> MAP_SHIFT];
        if (g >= PIN_BASE && g < PIN_BASE + N_PIN) begin : g_pin
            assign src_mode[g] = pin_mode_q[g - PIN_BASE];
        end else begin : g_fixed
            assign src_mode[g] = FIXED_LOW[g] ? TRIG_LOW : TRIG_RISE;
        end
        vic_src_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
            .clk  (clk),
            .rst  (rst),
            .raw  (src_in[g]),
            .mode (src_mode[g]),
            .hit  (hit[g])
        );
    end

    // ---------------- register port decode ----------------
    always_comb begin
        wr_byte = bus_wr && !bus_size;
        wr_half = bus_wr && bus_size;
        wr_flag = wr_byte && rgn == RGN_FLAG && 32'(off) < N_SRC;
        wr_en   = wr_byte && rgn == RGN_EN   && 32'(off) < N_EN;
        wr_prio = wr_byte && rgn == RGN_PRIO && 32'(off) < N_PRIO;
        wr_pin  = wr_byte && rgn == RGN_CTRL && 32'(off) < N_PIN;
        wr_swi  = wr_byte && rgn == RGN_CTRL && off == OFF_SWI && bus_wdata[0];
        wr_fast = wr_half && rgn == RGN_CTRL && off == OFF_FAST;
    end

    // ---------------- flag update and rescan candidates ----------------
    always_comb begin
        ack_take = ack_in && req_valid;
        for (int n = 0; n < N_SRC; n++) begin
            ack_edge[n] = ack_take && req_src == IW'(n) && src_mode[n] != TRIG_LOW;
            if (src_mode[n] == TRIG_LOW) begin
                flag_d[n] = hit[n];
            end else begin
                flag_d[n] = (flag_q[n]
                             && !(wr_flag && off[IW-1:0] == IW'(n) && !bus_wdata[0])
                             && !ack_edge[n]) || hit[n];
            end
        end
        pick_cand = (ack_take ? (flag_q & ~ack_edge) : hit) & en_bits
                    & ~N_SRC'(1);
    end

    vic_pick #(.N(N_SRC), .PW(8), .IW(IW)) u_pick (
        .cand  (pick_cand),
        .prio  (src_prio),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q    <= '0;
            en_q      <= '0;
            prio_q    <= '0;
            fast_q    <= '0;
            req_valid <= 1'b0;
            req_src   <= '0;
            swi_q     <= 1'b0;
            for (int i = 0; i < N_PIN; i++) pin_mode_q[i] <= TRIG_RISE;
        end else begin
            flag_q <= flag_d;
            swi_q  <= wr_swi;
            if (wr_en)   en_q[off[EN_IW-1:0]]         <= bus_wdata[7:0];
            if (wr_prio) prio_q[off[PR_IW-1:0]]       <= bus_wdata[7:0];
            if (wr_pin)  pin_mode_q[off[PIN_IW-1:0]]  <= trig_e'(bus_wdata[3:2]);
            if (wr_fast) fast_q <= '{en: bus_wdata[15], vec: bus_wdata[7:0]};

            if (ack_take) begin
                req_valid <= pick_found;
                req_src   <= pick_found ? pick_idx : '0;
            end else if (!req_valid) begin
                if (pick_found) begin
                    req_valid <= 1'b1;
                    req_src   <= pick_idx;
                end
            end else if (src_mode[req_src] == TRIG_LOW && !hit[req_src]) begin
                req_valid <= 1'b0;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        word.prio  = src_prio[req_src];
        word.vec   = 8'(req_src);
        steer      = fast_q.en && fast_q.vec == word.vec;
        irq_level  = (req_valid && !steer) ? word : '0;
        fast_level = (req_valid && steer)  ? word : '0;
    end

    assign swi_pulse = swi_q;

    always_comb begin
        bus_rdata = '0;
        if (!bus_size) begin
            case (rgn)
                RGN_FLAG: if (32'(off) < N_SRC)  bus_rdata = {15'b0, flag_q[off[IW-1:0]]};
                RGN_EN:   if (32'(off) < N_EN)   bus_rdata = {8'b0, en_q[off[EN_IW-1:0]]};
                RGN_PRIO: if (32'(off) < N_PRIO) bus_rdata = {8'b0, prio_q[off[PR_IW-1:0]]};
                default:  if (32'(off) < N_PIN)
                              bus_rdata = {12'b0, pin_mode_q[off[PIN_IW-1:0]], 2'b00};
            endcase
        end else if (rgn == RGN_CTRL && off == OFF_FAST) begin
            bus_rdata = {fast_q.en, 7'b0, fast_q.vec};
        end
    end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
#(
    parameter int IW = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              ack_in,
    input logic              bus_wr,
    input logic              bus_size,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              wdata0,
    input logic [15:0]       bus_rdata,
    input logic [15:0]       irq_level,
    input logic [15:0]       fast_level,
    input logic              swi_pulse,
    input logic              req_valid,
    input logic [IW-1:0]     req_src
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (irq_level == '0 && fast_level == '0));

    // R7
    fast_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_level != '0 && fast_level != '0));

    // R5
    src_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_src != '0);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ack_in) |=> (!req_valid || $stable(req_src)));

    // R11
    swi_cause_chk: assert property (@(posedge clk) disable iff (rst)
        swi_pulse |-> $past(bus_wr && !bus_size
                            && bus_addr == {RGN_CTRL, OFF_SWI} && wdata0));

    // R12
    size_read_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_size && bus_addr != {RGN_CTRL, OFF_FAST})
         || (!bus_size && bus_addr == {RGN_CTRL, OFF_FAST})) |-> bus_rdata == '0);
endmodule

bind vec_intc vic_chk #(.IW(IW)) u_vic_chk (
    .clk        (clk),
    .rst        (rst),
    .ack_in     (ack_in),
    .bus_wr     (bus_wr),
    .bus_size   (bus_size),
    .bus_addr   (bus_addr),
    .wdata0     (bus_wdata[0]),
    .bus_rdata  (bus_rdata),
    .irq_level  (irq_level),
    .fast_level (fast_level),
    .swi_pulse  (swi_pulse),
    .req_valid  (req_valid),
    .req_src    (req_src)
);

// File: tb/test_vec_intc.sv
module test_vec_intc;
    import vic_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_in = '0;
    logic          ack_in = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_size = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata, irq_level, fast_level;
    logic          swi_pulse;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vec_intc i_vec_intc (
        .clk, .rst, .src_in, .ack_in, .bus_wr, .bus_size, .bus_addr,
        .bus_wdata, .bus_rdata, .irq_level, .fast_level, .swi_pulse
    );

    typedef enum int {K_IRQ, K_FAST, K_RD, K_SWI} kind_e;
    typedef struct {
        kind_e       kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        item_t       it;
        logic [15:0] got;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                K_IRQ:   got = irq_level;
                K_FAST:  got = fast_level;
                K_RD:    got = bus_rdata;
                default: got = {15'b0, swi_pulse};
            endcase
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s: got=%h exp=%h", it.tag, got, it.exp);
            end
        end
    end

    function automatic logic [9:0] adr(logic [1:0] r, int o);
        return {r, 8'(o)};
    endfunction

    task automatic push(kind_e k, logic [15:0] e, string t);
        item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic reg_wr(logic [9:0] a, logic sz, logic [15:0] d);
        tick();
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(logic [9:0] a, logic sz, logic [15:0] e, string t);
        tick();
        bus_addr = a; bus_size = sz;
        push(K_RD, e, t);
    endtask

    task automatic set_src(int n, logic v);
        tick();
        src_in[n] = v;
        repeat (3) tick();
    endtask

    task automatic expect_req(logic [15:0] irq, logic [15:0] fst, string t);
        push(K_IRQ, irq, t);
        push(K_FAST, fst, {t, " (fast out)"});
    endtask

    task automatic ack();
        tick(); ack_in = 1'b1;
        tick(); ack_in = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        src_in[17] = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_req(16'h0000, 16'h0000, "R1 outputs after reset");
        reg_rd(adr(RGN_FLAG, 5), 0, 16'h0000, "R1 flag after reset");
        reg_rd(adr(RGN_EN, 0),   0, 16'h0000, "R1 enable after reset");
        reg_rd(adr(RGN_PRIO, 2), 0, 16'h0000, "R1 priority after reset");
        reg_rd(adr(RGN_CTRL, 0), 0, 16'h0008, "R1 pin mode after reset");

        // R3 pin modes: src17 low level, src18 both edges
        reg_wr(adr(RGN_CTRL, 1), 0, 16'h0000);
        reg_wr(adr(RGN_CTRL, 2), 0, 16'h000C);
        reg_rd(adr(RGN_CTRL, 2), 0, 16'h000C, "R3 pin mode readback");

        // priorities (R4 map: slot = source >> 1)
        reg_wr(adr(RGN_PRIO, 2), 0, 16'h0003);
        reg_wr(adr(RGN_PRIO, 4), 0, 16'h0007);
        reg_wr(adr(RGN_PRIO, 5), 0, 16'h0007);
        reg_wr(adr(RGN_PRIO, 6), 0, 16'h0002);
        reg_wr(adr(RGN_PRIO, 8), 0, 16'h0005);
        reg_wr(adr(RGN_PRIO, 9), 0, 16'h0006);

        // R6 disabled source sets flag, no request
        set_src(5, 1'b1);
        expect_req(16'h0000, 16'h0000, "R6 disabled source raises nothing");
        reg_rd(adr(RGN_FLAG, 5), 0, 16'h0001, "R2 rising edge sets flag");
        set_src(5, 1'b0);
        reg_wr(adr(RGN_FLAG, 5), 0, 16'h0000);
        reg_rd(adr(RGN_FLAG, 5), 0, 16'h0000, "R10 zero write clears edge flag");

        reg_wr(adr(RGN_EN, 0), 0, 16'h0021);
        reg_wr(adr(RGN_EN, 1), 0, 16'h003E);
        reg_wr(adr(RGN_EN, 2), 0, 16'h0007);
        reg_rd(adr(RGN_EN, 1), 0, 16'h003E, "R6 enable byte readback");

        // R5 source zero never requests
        set_src(0, 1'b1);
        expect_req(16'h0000, 16'h0000, "R5 source zero ignored");
        set_src(0, 1'b0);

        // R4 request word
        set_src(5, 1'b1);
        expect_req(16'h0305, 16'h0000, "R4 priority and vector word");
        set_src(5, 1'b0);

        // R5 outstanding request blocks new ones
        tick(); src_in[12:9] = 4'hF;
        repeat (3) tick();
        expect_req(16'h0305, 16'h0000, "R5 outstanding request held");
        tick(); src_in[12:9] = 4'h0;

        // R9 rescans
        ack();
        expect_req(16'h0709, 16'h0000, "R9 rescan picks highest priority");
        reg_rd(adr(RGN_FLAG, 5), 0, 16'h0000, "R9 acked edge flag cleared");
        ack();
        expect_req(16'h070A, 16'h0000, "R9 tie goes to lowest source");
        ack();
        expect_req(16'h070B, 16'h0000, "R9 next tied source");
        ack();
        expect_req(16'h020C, 16'h0000, "R9 lower priority last");
        ack();
        expect_req(16'h0000, 16'h0000, "R9 nothing left pending");

        // R7 fast steering
        reg_wr(adr(RGN_CTRL, 8'hF2), 1, 16'h800D);
        reg_rd(adr(RGN_CTRL, 8'hF2), 1, 16'h800D, "R7 fast register readback");
        reg_rd(adr(RGN_CTRL, 8'hF2), 0, 16'h0000, "R12 byte read of fast register");
        set_src(13, 1'b1);
        expect_req(16'h0000, 16'h020D, "R7 matching vector steered to fast");
        set_src(13, 1'b0);
        ack();
        expect_req(16'h0000, 16'h0000, "R9 fast request acknowledged");

        // R12 wrong-size access
        reg_wr(adr(RGN_PRIO, 6), 1, 16'h0009);
        reg_rd(adr(RGN_PRIO, 6), 0, 16'h0002, "R12 halfword write ignored");
        reg_rd(adr(RGN_PRIO, 6), 1, 16'h0000, "R12 halfword read returns zero");

        // R2 falling-edge pin
        reg_wr(adr(RGN_CTRL, 0), 0, 16'h0004);
        reg_rd(adr(RGN_CTRL, 0), 0, 16'h0004, "R3 falling mode readback");
        set_src(16, 1'b1);
        expect_req(16'h0000, 16'h0000, "R2 falling mode ignores rise");
        set_src(16, 1'b0);
        expect_req(16'h0510, 16'h0000, "R2 falling edge requests");
        ack();
        expect_req(16'h0000, 16'h0000, "R9 falling source acknowledged");

        // R2 / R8 / R10 level source
        set_src(17, 1'b0);
        expect_req(16'h0511, 16'h0000, "R2 active-low level requests");
        reg_wr(adr(RGN_FLAG, 17), 0, 16'h0000);
        reg_rd(adr(RGN_FLAG, 17), 0, 16'h0001, "R10 level flag not cleared by write");
        set_src(17, 1'b1);
        expect_req(16'h0000, 16'h0000, "R8 level deassert drops request");
        reg_rd(adr(RGN_FLAG, 17), 0, 16'h0000, "R8 level flag follows input");

        // R2 both edges
        set_src(18, 1'b1);
        expect_req(16'h0612, 16'h0000, "R2 both-edge mode on rise");
        ack();
        expect_req(16'h0000, 16'h0000, "R9 both-edge acknowledged");
        set_src(18, 1'b0);
        expect_req(16'h0612, 16'h0000, "R2 both-edge mode on fall");
        ack();

        // R11 software interrupt
        reg_wr(adr(RGN_CTRL, 8'hF0), 0, 16'h0001);
        push(K_SWI, 16'h0001, "R11 pulse after write");
        tick();
        push(K_SWI, 16'h0000, "R11 pulse lasts one cycle");
        reg_wr(adr(RGN_CTRL, 8'hF0), 0, 16'h0000);
        push(K_SWI, 16'h0000, "R11 bit0 clear gives no pulse");

        repeat (2) @(negedge clk);
        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule